// File: doc/BRIEF.md
# Ethernet Receive Frame Stripper

This block sits behind a byte-wide gigabit receive interface that supplies a data byte, a data-valid flag and a line-error flag on each clock. It looks for the start of each frame, throws away the preamble and the start delimiter, and runs a CRC-32 over everything that follows. It forwards the frame bytes on a byte-wide streaming output, and the final byte carries an end marker.

When stripping is switched on, the four-byte frame check sequence is removed. Short frames whose length/type field announces fewer than 46 payload bytes are also cut back to their real size, so the trailing pad bytes are not forwarded. Because the block can only tell that a byte belongs to the check sequence once the line goes idle, incoming bytes pass through a short hold line. The hold line is as deep as the check sequence plus one byte. Every frame that had a valid start delimiter produces a one-cycle status record, even when the frame had errors. The record holds the byte count together with flags for a CRC mismatch, a frame over the programmed limit, a line error, and a frame below the minimum size.

Top module: `rx_frame_strip`

## Requirements
- R1: A frame begins when the line carries one or more 0x55 bytes followed by 0xD5 while `rx_dv` is high. Neither the 0x55 bytes nor the 0xD5 byte ever appear on the output.
- R2: A burst with no valid delimiter is discarded silently, with no output byte and no status record. Such a burst is one whose first byte is not 0x55, or where a byte other than 0x55 or 0xD5 follows the 0x55 run, or where `rx_dv` drops during the 0x55 run.
- R3: With stripping off, every byte after the delimiter is forwarded in order, including the four check bytes. `out_last` is set only on the final byte, and always together with `out_valid`.
- R4: With stripping on, the last four received bytes are withheld and the last byte forwarded carries `out_last`. No byte is forwarded for a frame of four bytes or fewer.
- R5: With stripping on, the frame is cut to 14 + V bytes when it has at least 14 bytes and V < 46. V is the 16-bit value in frame bytes 12 (high) and 13 (low), counted from 0 after the delimiter. After the cut, `out_last` is not followed by `out_valid` in the next cycle.
- R6: On the clock edge that samples `rx_dv` low at the end of a frame, `stat_valid` rises for exactly one cycle. `stat_len` then equals the number of bytes received after the delimiter, check bytes included.
- R7: `stat_crc_err` is 1 unless the CRC-32 residue over all received bytes is 0xDEBB20E3 in LSB-first register form (0xC704DD7B in MSB-first form). The CRC is reflected, uses polynomial 0xEDB88320, starts from all ones, and the check bytes are sent least significant byte first.
- R8: `stat_long_err` is 1 exactly when `stat_len` exceeds `cfg_max_len`.
- R9: `stat_rx_err` is 1 exactly when `rx_er` was high on any byte after the delimiter.
- R10: `stat_runt` is 1 exactly when `stat_len` is below 64.
- R11: After reset all outputs are 0. The status fields keep their values between `stat_valid` pulses.
- R12: The stripping choice is taken from `cfg_strip_en` at the delimiter, so a change during a frame has no effect on that frame.

Between frames, `rx_dv` must stay low for at least six cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_strip_en | input | 1 | 1 removes the check sequence and the padding |
| cfg_max_len | input | 16 | Largest byte count accepted without a length error |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive line error |
| rx_data | input | 8 | Receive byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final output byte of the frame |
| stat_valid | output | 1 | One-cycle status strobe |
| stat_len | output | 16 | Bytes received after the delimiter |
| stat_crc_err | output | 1 | CRC residue mismatch |
| stat_long_err | output | 1 | Byte count above `cfg_max_len` |
| stat_rx_err | output | 1 | Line error seen during the frame |
| stat_runt | output | 1 | Byte count below 64 |

## Verification
A hold-line fill count that is off by one shows up on the first frame. That frame has an extra or a missing byte, or a displaced `out_last`, and this is visible within a few cycles of `rx_dv` falling. A wrong captured length/type value or a stale cut flag moves the end of a padded frame, and this shows at the first cut frame. A corrupted CRC register or frame counter reaches the status record at the next frame end. The bench therefore sweeps every frame length from 4 to 76 bytes against several length/type values, with stripping both on and off, and compares every output byte and status field.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    localparam logic [7:0]  PRE_BYTE      = 8'h55;
    localparam logic [7:0]  SFD_BYTE      = 8'hD5;
    localparam logic [31:0] CRC_POLY_R    = 32'hEDB88320;
    localparam logic [31:0] CRC_RESIDUE_R = 32'hDEBB20E3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_BODY,
        ST_SKIP,
        ST_FLUSH
    } rx_state_t;

    // One byte of reflected CRC-32, least significant bit first.
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY_R;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/rxs_crc_acc.sv
module rxs_crc_acc
    import rxs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init,
    input  logic       en,
    input  logic [7:0] din,
    output logic       good
);

    typedef struct packed {
        logic [31:0] crc;
    } crc_st_t;

    crc_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (init)    s_d.crc = '1;
        else if (en) s_d.crc = crc_step(s_q.crc, din);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q.crc <= '1;
        else        s_q     <= s_d;
    end

    assign good = (s_q.crc == CRC_RESIDUE_R);

endmodule

// File: rtl/rxs_delay.sv
module rxs_delay #(
    parameter int unsigned DEPTH = 5,
    parameter int unsigned W     = 8,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] fill,
    output logic          full
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [CW-1:0]           cnt;
    } dl_t;

    dl_t s_d, s_q;
    logic [CW-1:0] oldest;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.cnt = '0;
        end else if (push) begin
            for (int i = DEPTH - 1; i > 0; i--) s_d.mem[i] = s_q.mem[i-1];
            s_d.mem[0] = din;
            if (s_q.cnt != CW'(DEPTH)) s_d.cnt = s_q.cnt + 1'b1;
        end else if (pop && s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign oldest = (s_q.cnt == '0) ? '0 : s_q.cnt - 1'b1;
    assign dout   = s_q.mem[oldest];
    assign fill   = s_q.cnt;
    assign full   = (s_q.cnt == CW'(DEPTH));

endmodule

// File: rtl/rx_frame_strip.sv
module rx_frame_strip
    import rxs_pkg::*;
#(
    parameter int unsigned LEN_W     = 16,
    parameter int unsigned FCS_BYTES = 4,
    parameter int unsigned HDR_BYTES = 14,
    parameter int unsigned PAD_MIN   = 46,
    parameter int unsigned MIN_FRAME = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_strip_en,
    input  logic [LEN_W-1:0] cfg_max_len,
    input  logic             rx_dv,
    input  logic             rx_er,
    input  logic [7:0]       rx_data,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_last,
    output logic             stat_valid,
    output logic [LEN_W-1:0] stat_len,
    output logic             stat_crc_err,
    output logic             stat_long_err,
    output logic             stat_rx_err,
    output logic             stat_runt
);

    localparam int unsigned HOLD  = FCS_BYTES + 1;
    localparam int unsigned CW    = $clog2(HOLD + 1);
    localparam int unsigned LT_HI = HDR_BYTES - 2;
    localparam int unsigned LT_LO = HDR_BYTES - 1;

    typedef struct packed {
        rx_state_t        state;
        logic [LEN_W-1:0] cnt;
        logic             strip;
        logic [15:0]      ltv;
        logic             lt_ok;
        logic             done;
        logic             rxe;
        logic [CW-1:0]    rem;
        logic             out_v;
        logic [7:0]       out_d;
        logic             out_l;
        logic             st_v;
        logic [LEN_W-1:0] st_len;
        logic             st_crc;
        logic             st_long;
        logic             st_rxe;
        logic             st_runt;
    } top_t;

    top_t s_d, s_q;

    logic          dl_clr, dl_push, dl_pop, dl_full;
    logic [7:0]    dl_dout;
    logic [CW-1:0] dl_fill;
    logic          crc_init, crc_en, crc_good;
    logic          pad_cut;
    logic [LEN_W-1:0] lim, pop_idx;

    rxs_delay #(.DEPTH(HOLD), .W(8)) u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (dl_clr),
        .push (dl_push),
        .pop  (dl_pop),
        .din  (rx_data),
        .dout (dl_dout),
        .fill (dl_fill),
        .full (dl_full)
    );

    rxs_crc_acc u_crc (
        .clk  (clk),
        .rst_n(rst_n),
        .init (crc_init),
        .en   (crc_en),
        .din  (rx_data),
        .good (crc_good)
    );

    assign pad_cut = s_q.strip && s_q.lt_ok && (s_q.ltv < 16'(PAD_MIN));
    assign lim     = LEN_W'(HDR_BYTES) + LEN_W'(s_q.ltv);
    assign pop_idx = s_q.cnt - LEN_W'(HOLD);

    always_comb begin
        s_d       = s_q;
        s_d.out_v = 1'b0;
        s_d.out_l = 1'b0;
        s_d.st_v  = 1'b0;
        dl_clr    = 1'b0;
        dl_push   = 1'b0;
        dl_pop    = 1'b0;
        crc_init  = 1'b0;
        crc_en    = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (rx_dv) s_d.state = (rx_data == PRE_BYTE) ? ST_PRE : ST_SKIP;
            end
            ST_PRE: begin
                if (!rx_dv) begin
                    s_d.state = ST_IDLE;
                end else if (rx_data == SFD_BYTE) begin
                    s_d.state = ST_BODY;
                    s_d.cnt   = '0;
                    s_d.strip = cfg_strip_en;
                    s_d.lt_ok = 1'b0;
                    s_d.done  = 1'b0;
                    s_d.rxe   = 1'b0;
                    dl_clr    = 1'b1;
                    crc_init  = 1'b1;
                end else if (rx_data != PRE_BYTE) begin
                    s_d.state = ST_SKIP;
                end
            end
            ST_SKIP: begin
                if (!rx_dv) s_d.state = ST_IDLE;
            end
            ST_BODY: begin
                if (rx_dv) begin
                    dl_push = 1'b1;
                    crc_en  = 1'b1;
                    if (s_q.cnt != '1) s_d.cnt = s_q.cnt + 1'b1;
                    if (rx_er) s_d.rxe = 1'b1;
                    if (s_q.cnt == LEN_W'(LT_HI)) s_d.ltv[15:8] = rx_data;
                    if (s_q.cnt == LEN_W'(LT_LO)) begin
                        s_d.ltv[7:0] = rx_data;
                        s_d.lt_ok    = 1'b1;
                    end
                    if (dl_full && !s_q.done && (!pad_cut || pop_idx < lim)) begin
                        s_d.out_v = 1'b1;
                        s_d.out_d = dl_dout;
                        if (pad_cut && pop_idx == lim - 1'b1) begin
                            s_d.out_l = 1'b1;
                            s_d.done  = 1'b1;
                        end
                    end
                end else begin
                    s_d.st_v    = 1'b1;
                    s_d.st_len  = s_q.cnt;
                    s_d.st_crc  = !crc_good;
                    s_d.st_long = s_q.cnt > cfg_max_len;
                    s_d.st_rxe  = s_q.rxe;
                    s_d.st_runt = s_q.cnt < LEN_W'(MIN_FRAME);
                    if (!s_q.strip)                 s_d.rem = dl_fill;
                    else if (dl_full && !s_q.done)  s_d.rem = CW'(1);
                    else                            s_d.rem = '0;
                    s_d.state = (s_d.rem != '0) ? ST_FLUSH : ST_IDLE;
                end
            end
            ST_FLUSH: begin
                dl_pop    = 1'b1;
                s_d.out_v = 1'b1;
                s_d.out_d = dl_dout;
                s_d.rem   = s_q.rem - 1'b1;
                if (s_q.rem == CW'(1)) begin
                    s_d.out_l = 1'b1;
                    s_d.state = ST_IDLE;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid     = s_q.out_v;
    assign out_data      = s_q.out_d;
    assign out_last      = s_q.out_l;
    assign stat_valid    = s_q.st_v;
    assign stat_len      = s_q.st_len;
    assign stat_crc_err  = s_q.st_crc;
    assign stat_long_err = s_q.st_long;
    assign stat_rx_err   = s_q.st_rxe;
    assign stat_runt     = s_q.st_runt;

endmodule

// File: rtl/rxs_checker.sv
module rxs_checker #(
    parameter int unsigned LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_valid,
    input logic             out_last,
    input logic             stat_valid,
    input logic [LEN_W-1:0] stat_len,
    input logic             stat_long_err,
    input logic [LEN_W-1:0] cfg_max_len
);

    AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid); // R3

    AST_QUIET_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> !out_valid); // R5

    AST_STAT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |=> !stat_valid); // R6

    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_valid |-> $stable(stat_len)); // R11

    AST_LEN_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && !stat_long_err) |-> (stat_len <= cfg_max_len)); // R8

endmodule

bind rx_frame_strip rxs_checker #(.LEN_W(LEN_W)) u_rxs_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .out_valid    (out_valid),
    .out_last     (out_last),
    .stat_valid   (stat_valid),
    .stat_len     (stat_len),
    .stat_long_err(stat_long_err),
    .cfg_max_len  (cfg_max_len)
);

// File: tb/tb_rx_frame_strip.sv
module tb_rx_frame_strip;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_strip_en;
    logic [15:0] cfg_max_len;
    logic        rx_dv, rx_er;
    logic [7:0]  rx_data;
    logic        out_valid, out_last, stat_valid;
    logic [7:0]  out_data;
    logic [15:0] stat_len;
    logic        stat_crc_err, stat_long_err, stat_rx_err, stat_runt;

    always #5 clk = ~clk;

    rx_frame_strip dut (
        .clk(clk), .rst_n(rst_n), .cfg_strip_en(cfg_strip_en), .cfg_max_len(cfg_max_len),
        .rx_dv(rx_dv), .rx_er(rx_er), .rx_data(rx_data),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .stat_valid(stat_valid), .stat_len(stat_len), .stat_crc_err(stat_crc_err),
        .stat_long_err(stat_long_err), .stat_rx_err(stat_rx_err), .stat_runt(stat_runt)
    );

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0] frm [0:255];
    logic [7:0] cap [0:255];
    int ncap, nlast, last_pos, nstat;
    logic [15:0] s_len;
    logic s_crc, s_long, s_rxe, s_runt;

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (ncap < 256) cap[ncap] = out_data;
                if (out_last) begin
                    nlast++;
                    last_pos = ncap;
                end
                ncap++;
            end
            if (stat_valid) begin
                nstat++;
                s_len  = stat_len;
                s_crc  = stat_crc_err;
                s_long = stat_long_err;
                s_rxe  = stat_rx_err;
                s_runt = stat_runt;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c;
        for (int k = 0; k < 8; k++) r = (r[0] ^ b[k]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        return r;
    endfunction

    task automatic drive(input logic dv, input logic er, input logic [7:0] d);
        @(negedge clk);
        rx_dv = dv; rx_er = er; rx_data = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 8'h00);
    endtask

    task automatic clear_cap();
        ncap = 0; nlast = 0; last_pos = -1; nstat = 0;
    endtask

    // Body of N bytes with length/type lt at bytes 12..13, then the four check bytes.
    task automatic build(input int n, input int lt, input int seed, input bit bad);
        logic [31:0] c;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++) begin
            frm[i] = 8'((i * 13 + seed) & 255);
            if (i == 12) frm[i] = 8'(lt >> 8);
            if (i == 13) frm[i] = 8'(lt & 255);
            c = crc_byte(c, frm[i]);
        end
        c = ~c;
        for (int j = 0; j < 4; j++) frm[n + j] = 8'(c >> (8 * j));
        if (bad) frm[n] = frm[n] ^ 8'h01;
    endtask

    task automatic run_frame(input bit s, input int npre, input int len, input int er_at,
                             input int flip_at, input string dtag);
        int exp_n, lt, bad_bytes;
        logic [31:0] c;
        clear_cap();
        cfg_strip_en = s;
        for (int i = 0; i < npre; i++) drive(1'b1, 1'b0, 8'h55);
        drive(1'b1, 1'b0, 8'hD5);
        for (int i = 0; i < len; i++) begin
            drive(1'b1, (i == er_at), frm[i]);
            if (i == flip_at) cfg_strip_en = ~s;
        end
        idle(12);
        cfg_strip_en = s;
        // expectations
        if (!s) exp_n = len;
        else begin
            exp_n = (len > 4) ? len - 4 : 0;
            if (len >= 14) begin
                lt = {frm[12], frm[13]};
                if (lt < 46 && exp_n > 14 + lt) exp_n = 14 + lt;
            end
        end
        c = 32'hFFFFFFFF;
        for (int i = 0; i < len; i++) c = crc_byte(c, frm[i]);
        bad_bytes = 0;
        for (int i = 0; i < exp_n && i < 256; i++) if (cap[i] !== frm[i]) bad_bytes++;
        chk(ncap == exp_n, {dtag, " byte count"}, ncap, exp_n);
        chk(bad_bytes == 0, {dtag, " byte values"}, bad_bytes, 0);
        chk(nlast == (exp_n > 0 ? 1 : 0), {dtag, " last count"}, nlast, exp_n > 0 ? 1 : 0);
        if (exp_n > 0) chk(last_pos == exp_n - 1, {dtag, " last position"}, last_pos, exp_n - 1);
        chk(nstat == 1, "R6 status count", nstat, 1);
        chk(s_len == 16'(len), "R6 status length", int'(s_len), len);
        chk(s_crc == (c != 32'hDEBB20E3), "R7 crc flag", s_crc, (c != 32'hDEBB20E3));
        chk(s_long == (len > int'(cfg_max_len)), "R8 long flag", s_long, (len > int'(cfg_max_len)));
        chk(s_rxe == (er_at >= 0 && er_at < len), "R9 line error flag", s_rxe, (er_at >= 0 && er_at < len));
        chk(s_runt == (len < 64), "R10 runt flag", s_runt, (len < 64));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int lts [4];
        lts = '{5, 45, 46, 16'h0800};
        rst_n = 1'b0; cfg_strip_en = 1'b0; cfg_max_len = 16'd16383;
        rx_dv = 1'b0; rx_er = 1'b0; rx_data = 8'h00;
        clear_cap();
        repeat (4) @(negedge clk);
        // R11: reset state
        chk(out_valid == 1'b0 && out_last == 1'b0, "R11 reset output", out_valid, 0);
        chk(stat_valid == 1'b0 && stat_len == 16'd0, "R11 reset status", int'(stat_len), 0);
        rst_n = 1'b1;
        idle(3);

        // Sweep: strip on/off, body length 0..72, several length/type values
        for (int s = 0; s < 2; s++)
            for (int li = 0; li < 4; li++)
                for (int n = 0; n <= 72; n++) begin
                    build(n, lts[li], n + li, 1'b0);
                    run_frame(s[0], 7, n + 4,  -1, -1,
                              (s == 0) ? "R3" : ((lts[li] < 46 && n + 4 >= 14) ? "R5" : "R4"));
                end

        // R1: single preamble byte
        build(50, 16'h0800, 3, 1'b0);
        run_frame(1'b0, 1, 54, -1, -1, "R1");
        // R7: corrupted check bytes
        build(60, 16'h0800, 9, 1'b1);
        run_frame(1'b1, 7, 64, -1, -1, "R7");
        // R9: line error in body
        build(60, 16'h0800, 11, 1'b0);
        run_frame(1'b0, 7, 64, 5, -1, "R9");
        // R10/R6: empty frame
        run_frame(1'b1, 7, 0, -1, -1, "R10");
        // R8: length limit boundary
        cfg_max_len = 16'd60;
        build(56, 16'h0800, 4, 1'b0);
        run_frame(1'b1, 7, 60, -1, -1, "R8");
        build(57, 16'h0800, 4, 1'b0);
        run_frame(1'b1, 7, 61, -1, -1, "R8");
        cfg_max_len = 16'd16383;
        // R12: strip setting changed mid-frame, both directions
        build(26, 16'h0800, 2, 1'b0);
        run_frame(1'b1, 7, 30, -1, 3, "R12");
        run_frame(1'b0, 7, 30, -1, 3, "R12");

        // R11: status held during idle
        idle(20);
        chk(stat_len == 16'd30 && stat_valid == 1'b0, "R11 status hold", int'(stat_len), 30);

        // R2: bad delimiter after preamble
        clear_cap();
        for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, 8'h55);
        drive(1'b1, 1'b0, 8'h12);
        for (int i = 0; i < 20; i++) drive(1'b1, 1'b0, 8'(i));
        idle(12);
        chk(ncap == 0, "R2 bad delimiter output", ncap, 0);
        chk(nstat == 0, "R2 bad delimiter status", nstat, 0);
        // R2: preamble only
        clear_cap();
        for (int i = 0; i < 6; i++) drive(1'b1, 1'b0, 8'h55);
        idle(12);
        chk(ncap == 0 && nstat == 0, "R2 preamble only", ncap + nstat, 0);
        // R2: delimiter with no preamble
        clear_cap();
        drive(1'b1, 1'b0, 8'hD5);
        for (int i = 0; i < 20; i++) drive(1'b1, 1'b0, 8'h55);
        idle(12);
        chk(ncap == 0 && nstat == 0, "R2 no preamble", ncap + nstat, 0);
        // R1: a valid frame still follows
        build(60, 16'h0800, 7, 1'b0);
        run_frame(1'b1, 7, 64, -1, -1, "R1");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule